// File: doc/BRIEF.md
# Lock-Aware Eight-Way Pseudo-LRU Replacement Selector

This block picks which way of an eight-way set-associative cache is replaced next. For every set it keeps a seven-bit binary decision tree. The tree is always steered away from the most recently touched way. When the cache controller needs to replace a line, it asks for a victim in a given set. It supplies that set's per-way lock vector with the request, and one clock later the block returns the chosen way in two forms: a one-hot vector and a three-bit index.

Locks never rewrite the stored tree. They are folded into the four leaf decisions only on the way to the decoder. The rule is the same in each pair:

- A locked even way forces its leaf toward the odd partner.
- A locked odd way forces its leaf toward the even partner, unless the even way is also locked.

The root and middle levels are used as stored, so a lock cannot move the choice to the other half of the tree.

Each hit or fill is reported with an access strobe, the set and the way. The block then rewrites the three tree bits on that way's path, and the stored tree is otherwise left alone.

Top module: `plru_victim_sel`

## Requirements
- R1: After synchronous active-low reset every set's tree is all zeros and `vic_valid` is low, so a request with no locks on any set returns way 0.
- R2: `vic_valid` is high in exactly those cycles that follow a cycle with `vic_req` high; the way reported belongs to that earlier request.
- R3: Whenever `vic_valid` is high, `vic_way_oh` has exactly one bit set and that bit is bit `vic_way_idx`.
- R4: With no locks the tree bits T0..T6 (bit i of the stored state) decode as follows: T0=0 picks ways 0-3, T0=1 picks ways 4-7; T1 (lower half) or T2 (upper half) = 0 picks the lower pair; leaf T3..T6 for pairs 0..3 = 0 picks the even way, 1 the odd way.
- R5: With locks K0..K7 (`lock[i]` for way i), the leaf used for pair j is K(2j) | (T(3+j) & ~K(2j+1)); T0..T2 are used unchanged.
- R6: If the even way of a pair is locked, that even way is never selected; the odd way of the pair is taken whenever the tree reaches that pair, even if the odd way is also locked.
- R7: An access to way w sets T0 = ~w[2], sets T1 (w<4) or T2 (w>=4) to ~w[1], sets leaf T(3+w/2) to ~w[0], and leaves the other four tree bits unchanged.
- R8: The lock vector has no effect on the stored tree; a later request with no locks sees the tree as accesses left it.
- R9: Each set's tree is independent; accesses to one set do not change the victim of another.
- R10: When an access and a request hit the same set in the same cycle, the victim is computed from the tree before that access is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Hit or fill strobe |
| acc_set | input | SET_W | Set index of the access |
| acc_way | input | 3 | Way touched by the access |
| vic_req | input | 1 | Victim request strobe |
| vic_set | input | SET_W | Set index of the victim request |
| lock | input | 8 | Per-way lock vector of the requested set, bit i = way i |
| vic_valid | output | 1 | Victim outputs valid (one cycle after request) |
| vic_way_oh | output | 8 | One-hot victim way |
| vic_way_idx | output | 3 | Encoded victim way |

## Verification
The bench drives a set into each of the 128 tree states through accesses alone, which exercises the three-bit path update, and then asks for a victim under all 256 lock vectors. Two kinds of broken design would show up here. One would swap the roles of even and odd locks, and it would hand out a locked even way. One that applied locks to the root or middle levels would move the choice to the wrong half of the tree. A request with no locks after every sweep would catch a design that wrote the folded leaves back into storage, because it would return a stale or shifted way. A same-set access and request in one cycle would expose a design that forwards the freshly updated tree, since the victim it returns would be the post-update way. An untouched second set would expose any mix-up of set index decoding.

// File: rtl/plru_pkg.sv
// Package: shared widths and types of the eight-way pseudo-LRU selector.
// Assumes a fixed eight-way, three-level binary tree; bit i of a tree is Ti.
package plru_pkg;
    localparam int WAYS   = 8;
    localparam int WAY_W  = $clog2(WAYS);
    localparam int TREE_W = WAYS - 1;
    localparam int PAIRS  = WAYS / 2;

    typedef logic [TREE_W-1:0] tree_t;
    typedef logic [WAYS-1:0]   way_vec_t;
    typedef logic [WAY_W-1:0]  way_idx_t;
endpackage

// File: rtl/plru_tree_store.sv
// Module: per-set tree storage with path update on access.
// Does: holds one tree per set, rewrites the three bits on the accessed
// way's path so they point away from it, and reads the requested set.
// Assumes: read returns the stored value before any same-cycle update.
module plru_tree_store
    import plru_pkg::*;
#(
    parameter int NUM_SETS = 16,
    parameter int SET_W    = $clog2(NUM_SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd_en,
    input  logic [SET_W-1:0] upd_set,
    input  way_idx_t         upd_way,
    input  logic [SET_W-1:0] rd_set,
    output tree_t            rd_tree
);
    tree_t state_q [NUM_SETS];
    tree_t upd_next;

    // Purpose: build the new tree of the accessed set from its old value.
    always_comb begin
        upd_next    = state_q[upd_set];
        upd_next[0] = ~upd_way[2];
        if (upd_way[2]) upd_next[2] = ~upd_way[1];
        else            upd_next[1] = ~upd_way[1];
        upd_next[3 + int'(upd_way[2:1])] = ~upd_way[0];
    end

    // Purpose: clear every tree on reset, store the updated tree on access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < NUM_SETS; s++) state_q[s] <= '0;
        end else if (upd_en) begin
            state_q[upd_set] <= upd_next;
        end
    end

    assign rd_tree = state_q[rd_set];
endmodule

// File: rtl/plru_lock_fold.sv
// Module: folds per-way locks into the leaf decisions of a tree.
// Does: for each pair, a locked even way forces the leaf to the odd way and
// a locked odd way forces it to the even way unless the even one is locked.
// Assumes: upper tree levels are passed through untouched.
module plru_lock_fold
    import plru_pkg::*;
(
    input  tree_t    tree_in,
    input  way_vec_t lock,
    output tree_t    tree_eff
);
    assign tree_eff[2:0] = tree_in[2:0];

    for (genvar g = 0; g < PAIRS; g++) begin : g_pair
        // Purpose: effective leaf bit of pair g.
        assign tree_eff[3+g] = lock[2*g] | (tree_in[3+g] & ~lock[2*g+1]);
    end
endmodule

// File: rtl/plru_way_decode.sv
// Module: decodes an effective tree into a one-hot way and its index.
// Does: a way is chosen when root, middle and leaf bits on its path all
// point toward it; exactly one way matches for any tree value.
// Assumes: bit value 0 at any node points to the lower-numbered subtree.
module plru_way_decode
    import plru_pkg::*;
(
    input  tree_t    tree_eff,
    output way_vec_t way_oh,
    output way_idx_t way_idx
);
    for (genvar w = 0; w < WAYS; w++) begin : g_way
        localparam logic [WAY_W-1:0] WV = WAY_W'(w);
        logic mid_bit;
        // Purpose: middle-level bit on the path of way w.
        assign mid_bit   = WV[2] ? tree_eff[2] : tree_eff[1];
        // Purpose: way w is selected when every node on its path agrees.
        assign way_oh[w] = (tree_eff[0] == WV[2]) && (mid_bit == WV[1])
                        && (tree_eff[3 + w/2] == WV[0]);
    end

    // Purpose: encode the one-hot selection into an index.
    always_comb begin
        way_idx = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (way_oh[w]) way_idx = way_idx | WAY_W'(w);
        end
    end
endmodule

// File: rtl/plru_victim_sel.sv
// Module: top of the lock-aware eight-way pseudo-LRU victim selector.
// Does: updates the per-set tree on each access and returns a registered
// victim one cycle after each request, steered away from locked ways.
// Assumes: the lock vector belongs to the requested set and is sampled
// with the request; synchronous active-low reset.
module plru_victim_sel
    import plru_pkg::*;
#(
    parameter int NUM_SETS = 16,
    parameter int SET_W    = $clog2(NUM_SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_valid,
    input  logic [SET_W-1:0] acc_set,
    input  logic [2:0]       acc_way,
    input  logic             vic_req,
    input  logic [SET_W-1:0] vic_set,
    input  logic [7:0]       lock,
    output logic             vic_valid,
    output logic [7:0]       vic_way_oh,
    output logic [2:0]       vic_way_idx
);
    tree_t    rd_tree;
    tree_t    eff_tree;
    way_vec_t dec_oh;
    way_idx_t dec_idx;

    plru_tree_store #(.NUM_SETS(NUM_SETS), .SET_W(SET_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd_en  (acc_valid),
        .upd_set (acc_set),
        .upd_way (acc_way),
        .rd_set  (vic_set),
        .rd_tree (rd_tree)
    );

    plru_lock_fold u_fold (
        .tree_in  (rd_tree),
        .lock     (lock),
        .tree_eff (eff_tree)
    );

    plru_way_decode u_dec (
        .tree_eff (eff_tree),
        .way_oh   (dec_oh),
        .way_idx  (dec_idx)
    );

    // Purpose: register the victim and its valid flag one cycle after request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vic_valid   <= 1'b0;
            vic_way_oh  <= '0;
            vic_way_idx <= '0;
        end else begin
            vic_valid <= vic_req;
            if (vic_req) begin
                vic_way_oh  <= dec_oh;
                vic_way_idx <= dec_idx;
            end
        end
    end
endmodule

// File: rtl/plru_victim_sel_chk.sv
// Module: assertion checker bound to the victim selector top.
// Does: checks output timing, one-hot shape and even-lock avoidance.
module plru_victim_sel_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       vic_req,
    input logic [7:0] lock,
    input logic       vic_valid,
    input logic [7:0] vic_way_oh,
    input logic [2:0] vic_way_idx
);
    // R1: valid is low in the first cycle out of reset
    p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !vic_valid);

    // R2: a request produces valid one cycle later
    p_valid_after_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        vic_req |=> vic_valid);

    // R2: no valid without a request in the cycle before
    p_no_spurious_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !vic_req |=> !vic_valid);

    // R3: exactly one way is reported
    p_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        vic_valid |-> $countones(vic_way_oh) == 1);

    // R3: index and one-hot agree
    p_idx_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
        vic_valid |-> vic_way_oh[vic_way_idx]);

    for (genvar g = 0; g < 4; g++) begin : g_even
        // R6: a locked even way is never the victim
        p_even_lock_avoided_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (vic_req && lock[2*g]) |=> !vic_way_oh[2*g]);
    end
endmodule

bind plru_victim_sel plru_victim_sel_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .vic_req     (vic_req),
    .lock        (lock),
    .vic_valid   (vic_valid),
    .vic_way_oh  (vic_way_oh),
    .vic_way_idx (vic_way_idx)
);

// File: tb/plru_victim_sel_test.sv
module plru_victim_sel_test;
    localparam int NUM_SETS = 16;
    localparam int SET_W    = $clog2(NUM_SETS);

    logic             clk = 0;
    logic             rst_n = 0;
    logic             acc_valid = 0;
    logic [SET_W-1:0] acc_set = '0;
    logic [2:0]       acc_way = '0;
    logic             vic_req = 0;
    logic [SET_W-1:0] vic_set = '0;
    logic [7:0]       lock = '0;
    logic             vic_valid;
    logic [7:0]       vic_way_oh;
    logic [2:0]       vic_way_idx;

    plru_victim_sel #(.NUM_SETS(NUM_SETS)) uut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_set(acc_set),
        .acc_way(acc_way), .vic_req(vic_req), .vic_set(vic_set), .lock(lock),
        .vic_valid(vic_valid), .vic_way_oh(vic_way_oh), .vic_way_idx(vic_way_idx)
    );

    always #5 clk = ~clk;

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    done     = 0;
    bit    live     = 0;
    string cur_tag  = "R4";

    // reference state: one integer tree per set, bit i = Ti
    int    ref_tree [NUM_SETS];
    bit    exp_valid = 0;
    int    exp_idx   = 0;
    string exp_tag   = "R1";

    // walk the tree node by node, applying the lock rule at the leaves
    function automatic int ref_victim(int t, logic [7:0] k);
        int pair, leaf;
        if (((t >> 0) & 1) == 0) pair = ((t >> 1) & 1) ? 1 : 0;
        else                     pair = ((t >> 2) & 1) ? 3 : 2;
        if (k[2*pair])          leaf = 1;
        else if (k[2*pair+1])   leaf = 0;
        else                    leaf = (t >> (3 + pair)) & 1;
        return 2*pair + leaf;
    endfunction

    // point the three path bits away from way w
    function automatic int ref_touch(int t, int w);
        int r = t;
        int hi = w / 4, mid = (w / 2) % 2, lo = w % 2;
        r = (r & ~1) | (1 - hi);
        if (hi == 1) r = (r & ~(1 << 2)) | ((1 - mid) << 2);
        else         r = (r & ~(1 << 1)) | ((1 - mid) << 1);
        r = (r & ~(1 << (3 + w/2))) | ((1 - lo) << (3 + w/2));
        return r;
    endfunction

    // cycle-by-cycle reference: same inputs the design sees at this edge
    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (ref_tree[s]) ref_tree[s] = 0;
            exp_valid = 0;
        end else begin
            exp_valid = vic_req;
            if (vic_req) begin
                exp_idx = ref_victim(ref_tree[vic_set], lock);
                exp_tag = cur_tag;
            end
            if (acc_valid) ref_tree[acc_set] = ref_touch(ref_tree[acc_set], acc_way);
        end
    end

    // compare away from the active edge
    always @(negedge clk) begin
        if (live) begin
            n_checks++;
            if (vic_valid !== exp_valid) begin
                n_fail++;
                $display("FAIL R2 valid: actual %b expected %b", vic_valid, exp_valid);
            end else if (exp_valid) begin
                n_checks++;
                if (vic_way_idx !== 3'(exp_idx) || vic_way_oh !== 8'(1 << exp_idx)) begin
                    n_fail++;
                    $display("FAIL %s victim: actual idx %0d oh %b expected idx %0d oh %b",
                             exp_tag, vic_way_idx, vic_way_oh, exp_idx, 8'(1 << exp_idx));
                end
            end
        end
    end

    task automatic step(bit a, int aset, int aw, bit r, int rset, logic [7:0] k, string tag);
        @(negedge clk);
        acc_valid = a;  acc_set = SET_W'(aset); acc_way = 3'(aw);
        vic_req   = r;  vic_set = SET_W'(rset); lock    = k;
        cur_tag   = tag;
    endtask

    function automatic int pair_way(int j, int p);
        return 2*j + (((p >> (3 + j)) & 1) ? 0 : 1);
    endfunction

    // reach tree value p in set s through accesses only (R7)
    task automatic build(int s, int p);
        for (int j = 0; j < 4; j++) step(1, s, pair_way(j, p), 0, 0, 0, "R7");
        step(1, s, pair_way(((p >> 1) & 1) ? 0 : 1, p), 0, 0, 0, "R7");
        step(1, s, pair_way(((p >> 2) & 1) ? 2 : 3, p), 0, 0, 0, "R7");
        if (p & 1) step(1, s, pair_way(((p >> 1) & 1) ? 0 : 1, p), 0, 0, 0, "R7");
        else       step(1, s, pair_way(((p >> 2) & 1) ? 2 : 3, p), 0, 0, 0, "R7");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        live  = 1;
        // R1: every set returns way 0 after reset
        for (int s = 0; s < NUM_SETS; s++) step(0, 0, 0, 1, s, 8'h00, "R1");
        // R4 R5 R6 R7 R8: every tree value under every lock vector in set 3
        for (int p = 0; p < 128; p++) begin
            build(3, p);
            for (int k = 0; k < 256; k++)
                step(0, 0, 0, 1, 3, 8'(k), (k == 0) ? "R4" : ((k & 8'h55) != 0 ? "R6" : "R5"));
            step(0, 0, 0, 1, 3, 8'h00, "R8");
        end
        // R9: untouched set 9 still at reset tree
        step(0, 0, 0, 1, 9, 8'h00, "R9");
        // R10: same-set access and request, then post-update request
        build(6, 0);
        step(1, 6, 0, 1, 6, 8'h00, "R10");
        step(0, 0, 0, 1, 6, 8'h00, "R10");
        step(1, 6, 5, 1, 6, 8'h01, "R10");
        step(0, 0, 0, 1, 6, 8'h00, "R10");
        // R7: mixed random traffic across sets
        for (int i = 0; i < 3000; i++)
            step(1'($urandom_range(0, 1)), $urandom_range(0, NUM_SETS-1), $urandom_range(0, 7),
                 1'($urandom_range(0, 1)), $urandom_range(0, NUM_SETS-1),
                 8'($urandom_range(0, 255)), "R7");
        step(0, 0, 0, 0, 0, 0, "R2");
        step(0, 0, 0, 0, 0, 0, "R2");
        live = 0;
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule